// File: doc/BRIEF.md
# Controller Command Dispatcher with Seconds Clock

This block sits behind a byte transport that has already framed incoming host packets. The first byte of every packet names its type. Only controller-type packets are handled here. Their second byte selects a command, and the remaining bytes are that command's arguments. Each command accepts one exact argument count. A packet that passes this check is answered with an acknowledge packet that repeats the command byte. A packet that fails it is answered with an error packet that carries a fixed error code. Packets of any other type belong to other units and are dropped silently.

The block also keeps a 32-bit seconds counter whose epoch is midnight on 1 January 1904. Host commands can read and write this counter. Other commands raise one-cycle strobes toward the peripheral polling logic and the power controller. These strobes carry autopoll on/off, poll rate, device mask, powerdown and system reset. Replies leave on a valid/ready byte stream, and the final byte is flagged.

Top module: `ctl_cmd_dispatch`

## Requirements
- R1: After reset, inReady is 1, outValid is 0, and every strobe output is 0. The seconds counter starts at RESET_SECONDS, which defaults to 2082844800, the count of seconds from 1904-01-01 to 1970-01-01.
- R2: Packet type codes are: peripheral bus 0x00, controller 0x01, error 0x02, timer 0x03, power 0x04, I2C 0x05, power manager 0x06. A packet whose first byte is not 0x01, or a controller packet with no command byte, is consumed with no reply and no strobe.
- R3: A successful reply is 0x01, 0x00, the command byte, then any result bytes. outLast is high on the final byte only.
- R4: A command byte outside the set listed in R6 to R12 gets the reply 0x02, 0x02, 0x01, command byte.
- R5: A known command with the wrong number of argument bytes gets the reply 0x02, 0x05, 0x01, command byte. The command then has no effect: no strobe fires and the clock is not loaded. A packet with more arguments than the argument register holds is also a wrong count.
- R6: Get-time (0x03) takes zero arguments. It returns four result bytes, most significant first, holding the counter value in the evaluation cycle.
- R7: Set-time (0x09) takes exactly four argument bytes, most significant first. It loads them into the counter and restarts the one-second prescaler.
- R8: The counter increments once every TICKS_PER_SECOND clock cycles and wraps from 0xFFFFFFFF to 0.
- R9: Autopoll (0x01) takes one argument. It pulses autopollStrobe, and autopollOn is 1 when that argument is nonzero.
- R10: Set-rate (0x14) takes one argument, which must be nonzero. It pulses rateStrobe with rateMs set to that argument. A zero argument is treated as a wrong argument count (R5).
- R11: Device-list (0x19) takes two arguments. It pulses devMaskStrobe with devMask = first argument × 256 + second argument.
- R12: Powerdown (0x0A) and reset-system (0x11) take zero arguments and pulse powerdownStrobe or resetStrobe for one cycle. File-server-flag (0x13) and power-message (0x21) take one argument and are acknowledged without any strobe. At most one strobe is high in any cycle.
- R13: inReady is low from the acceptance of a packet's last byte until the last reply byte is taken. The first reply byte and any strobe appear in the second cycle after the last-byte acceptance edge. Reply bytes hold while outReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Incoming packet byte valid |
| inReady | output | 1 | Block can take an incoming byte |
| inData | input | 8 | Incoming packet byte |
| inLast | input | 1 | Incoming byte ends the packet |
| outValid | output | 1 | Reply byte valid |
| outReady | input | 1 | Sink takes the reply byte |
| outData | output | 8 | Reply byte |
| outLast | output | 1 | Reply byte is the last of its packet |
| autopollStrobe | output | 1 | One-cycle autopoll configuration pulse |
| autopollOn | output | 1 | Autopoll enable carried by the pulse |
| rateStrobe | output | 1 | One-cycle poll-rate pulse |
| rateMs | output | 8 | Poll period in milliseconds |
| devMaskStrobe | output | 1 | One-cycle device-mask pulse |
| devMask | output | 16 | Polled device mask |
| powerdownStrobe | output | 1 | One-cycle powerdown request |
| resetStrobe | output | 1 | One-cycle system reset request |

## Verification
The block takes the last packet byte on edge k and evaluates the command during the next cycle. At edge k+1 it registers the strobes, the reply kind and the time snapshot, and it loads the counter when set-time is accepted. So outValid is still low at the falling edge after k and is high at the falling edge after k+1. The bench drives and samples only on falling edges and checks outValid at both of those points. It predicts get-time from a model of the counter: the base value plus the number of elapsed counting edges divided by the tick period, measured from the load edge or from the last reset edge. Reply bytes are collected under random backpressure. Strobe pulses are counted at falling edges and compared with the expected counts after each packet.

// File: rtl/ctl_cmd_dispatch_pkg.sv
package ctl_cmd_dispatch_pkg;

  // packet type codes (first byte of every packet)
  localparam logic [7:0] TYPE_BUS   = 8'h00;
  localparam logic [7:0] TYPE_CTRL  = 8'h01;
  localparam logic [7:0] TYPE_ERROR = 8'h02;

  // error codes carried in byte 1 of an error reply
  localparam logic [7:0] ERR_UNKNOWN = 8'h02;
  localparam logic [7:0] ERR_BADARGS = 8'h05;

  // controller command bytes
  localparam logic [7:0] CMD_AUTOPOLL  = 8'h01;
  localparam logic [7:0] CMD_GET_TIME  = 8'h03;
  localparam logic [7:0] CMD_SET_TIME  = 8'h09;
  localparam logic [7:0] CMD_POWERDOWN = 8'h0A;
  localparam logic [7:0] CMD_RESET_SYS = 8'h11;
  localparam logic [7:0] CMD_FILE_SRV  = 8'h13;
  localparam logic [7:0] CMD_SET_RATE  = 8'h14;
  localparam logic [7:0] CMD_DEV_LIST  = 8'h19;
  localparam logic [7:0] CMD_PWR_MSG   = 8'h21;

  // reply lengths in bytes
  localparam int TIME_BYTES = 4;
  localparam int LEN_OK     = 3;
  localparam int LEN_TIME   = LEN_OK + TIME_BYTES;
  localparam int LEN_ERR    = 4;
  localparam int TX_IDX_W   = $clog2(LEN_TIME + 1);

  typedef enum logic [1:0] {RK_NONE, RK_OK, RK_UNKNOWN, RK_BADARGS} replyKind_t;
  typedef enum logic [1:0] {ST_RX, ST_EVAL, ST_TX} ctrlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       capType;
    logic       capCmd;
    logic       capArg;
    logic       commit;
    replyKind_t kind;
    logic       snapTime;
    logic       loadTime;
    logic       fireAutopoll;
    logic       fireRate;
    logic       fireMask;
    logic       firePower;
    logic       fireReset;
  } ctrlStrobes_t;

endpackage

// File: rtl/ctl_cmd_dispatch_ctrl.sv
module ctl_cmd_dispatch_ctrl
  import ctl_cmd_dispatch_pkg::*;
#(
  parameter int MAX_ARGS = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic                                 inLast,
  output logic                                 inReady,
  input  logic                                 outReady,
  output logic                                 outValid,
  output logic                                 outLast,
  output logic [TX_IDX_W-1:0]                  txIdx,
  input  logic [7:0]                           pktType,
  input  logic [7:0]                           cmdByte,
  input  logic [$clog2(MAX_ARGS+2)-1:0]        argCount,
  input  logic [7:0]                           argByte0,
  output ctrlStrobes_t                         strobes
);

  localparam int ARG_CNT_W = $clog2(MAX_ARGS + 2);
  localparam logic [1:0] POS_TYPE = 2'd0;
  localparam logic [1:0] POS_ARG  = 2'd2;

  ctrlState_t              state;
  logic [1:0]              rxPos;
  logic [TX_IDX_W-1:0]     lenQ;
  logic                    accept;

  replyKind_t              evKind;
  logic [TX_IDX_W-1:0]     evLen;
  logic evAp, evRate, evMask, evPwr, evRst, evSnap, evLoad;

  assign inReady  = (state == ST_RX);
  assign outValid = (state == ST_TX);
  assign accept   = inValid && inReady;
  assign outLast  = outValid && (txIdx == lenQ - 1'b1);

  function automatic logic argsAre(input logic [ARG_CNT_W-1:0] cnt, input int n);
    return cnt == ARG_CNT_W'(n);
  endfunction

  // command evaluation: argument count check and effect selection
  always_comb begin
    evKind = RK_NONE;
    evLen  = '0;
    evAp = 1'b0; evRate = 1'b0; evMask = 1'b0; evPwr = 1'b0; evRst = 1'b0;
    evSnap = 1'b0; evLoad = 1'b0;
    if (pktType == TYPE_CTRL && rxPos == POS_ARG) begin
      evKind = RK_OK;
      evLen  = TX_IDX_W'(LEN_OK);
      case (cmdByte)
        CMD_AUTOPOLL:  if (argsAre(argCount, 1)) evAp = 1'b1; else evKind = RK_BADARGS;
        CMD_SET_RATE:  if (argsAre(argCount, 1) && argByte0 != 8'h00) evRate = 1'b1;
                       else evKind = RK_BADARGS;
        CMD_DEV_LIST:  if (argsAre(argCount, 2)) evMask = 1'b1; else evKind = RK_BADARGS;
        CMD_POWERDOWN: if (argsAre(argCount, 0)) evPwr = 1'b1; else evKind = RK_BADARGS;
        CMD_RESET_SYS: if (argsAre(argCount, 0)) evRst = 1'b1; else evKind = RK_BADARGS;
        CMD_FILE_SRV,
        CMD_PWR_MSG:   if (!argsAre(argCount, 1)) evKind = RK_BADARGS;
        CMD_GET_TIME:  if (argsAre(argCount, 0)) begin
                         evSnap = 1'b1;
                         evLen  = TX_IDX_W'(LEN_TIME);
                       end else evKind = RK_BADARGS;
        CMD_SET_TIME:  if (argsAre(argCount, TIME_BYTES)) evLoad = 1'b1;
                       else evKind = RK_BADARGS;
        default:       evKind = RK_UNKNOWN;
      endcase
      if (evKind != RK_OK) evLen = TX_IDX_W'(LEN_ERR);
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.capType = accept && (rxPos == POS_TYPE);
    strobes.capCmd  = accept && (rxPos == 2'd1);
    strobes.capArg  = accept && (rxPos == POS_ARG);
    if (state == ST_EVAL) begin
      strobes.commit       = 1'b1;
      strobes.kind         = evKind;
      strobes.snapTime     = evSnap;
      strobes.loadTime     = evLoad;
      strobes.fireAutopoll = evAp;
      strobes.fireRate     = evRate;
      strobes.fireMask     = evMask;
      strobes.firePower    = evPwr;
      strobes.fireReset    = evRst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RX;
      rxPos <= POS_TYPE;
      txIdx <= '0;
      lenQ  <= '0;
    end else begin
      case (state)
        ST_RX: if (accept) begin
          if (rxPos != POS_ARG) rxPos <= rxPos + 2'd1;
          if (inLast) state <= ST_EVAL;
        end
        ST_EVAL: begin
          rxPos <= POS_TYPE;
          txIdx <= '0;
          lenQ  <= evLen;
          state <= (evKind == RK_NONE) ? ST_RX : ST_TX;
        end
        ST_TX: if (outReady) begin
          if (outLast) state <= ST_RX;
          else         txIdx <= txIdx + 1'b1;
        end
        default: state <= ST_RX;
      endcase
    end
  end

endmodule

// File: rtl/ctl_seconds_clock.sv
module ctl_seconds_clock #(
  parameter int          TICKS_PER_SECOND = 250_000_000,
  parameter logic [31:0] RESET_SECONDS    = 32'd2082844800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic [31:0] loadValue,
  output logic [31:0] seconds
);

  logic tick;

  if (TICKS_PER_SECOND > 1) begin : g_prescale
    localparam int PRE_W = $clog2(TICKS_PER_SECOND);
    logic [PRE_W-1:0] preQ;
    assign tick = (preQ == PRE_W'(TICKS_PER_SECOND - 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             preQ <= '0;
      else if (load || tick) preQ <= '0;
      else                   preQ <= preQ + 1'b1;
    end
  end else begin : g_direct
    assign tick = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     seconds <= RESET_SECONDS;
    else if (load) seconds <= loadValue;
    else if (tick) seconds <= seconds + 32'd1;
  end

endmodule

// File: rtl/ctl_cmd_dispatch_dpath.sv
module ctl_cmd_dispatch_dpath
  import ctl_cmd_dispatch_pkg::*;
#(
  parameter int          MAX_ARGS         = 4,
  parameter int          TICKS_PER_SECOND = 250_000_000,
  parameter logic [31:0] RESET_SECONDS    = 32'd2082844800
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    inData,
  input  ctrlStrobes_t                  strobes,
  input  logic [TX_IDX_W-1:0]           txIdx,
  output logic [7:0]                    pktType,
  output logic [7:0]                    cmdByte,
  output logic [$clog2(MAX_ARGS+2)-1:0] argCount,
  output logic [7:0]                    argByte0,
  output logic [7:0]                    outData,
  output logic                          autopollStrobe,
  output logic                          autopollOn,
  output logic                          rateStrobe,
  output logic [7:0]                    rateMs,
  output logic                          devMaskStrobe,
  output logic [15:0]                   devMask,
  output logic                          powerdownStrobe,
  output logic                          resetStrobe
);

  localparam int ARG_CNT_W = $clog2(MAX_ARGS + 2);
  localparam int ARG_W     = 8 * MAX_ARGS;

  logic [ARG_W-1:0] argWord;
  logic [31:0]      seconds;
  logic [31:0]      snapQ;
  replyKind_t       kindQ;
  logic             isOk;

  // packet capture: type, command, argument shift register, saturating count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktType  <= 8'h00;
      cmdByte  <= 8'h00;
      argWord  <= '0;
      argCount <= '0;
    end else begin
      if (strobes.capType) begin
        pktType  <= inData;
        argWord  <= '0;
        argCount <= '0;
      end
      if (strobes.capCmd) cmdByte <= inData;
      if (strobes.capArg) begin
        if (argCount < ARG_CNT_W'(MAX_ARGS)) argWord <= {argWord[ARG_W-9:0], inData};
        if (argCount != '1) argCount <= argCount + 1'b1;
      end
    end
  end

  assign argByte0 = argWord[7:0];

  ctl_seconds_clock #(
    .TICKS_PER_SECOND(TICKS_PER_SECOND),
    .RESET_SECONDS   (RESET_SECONDS)
  ) u_clock (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobes.loadTime),
    .loadValue(argWord[31:0]),
    .seconds  (seconds)
  );

  // reply state and side-effect strobes, registered at the evaluation edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ           <= RK_NONE;
      snapQ           <= '0;
      autopollStrobe  <= 1'b0;
      autopollOn      <= 1'b0;
      rateStrobe      <= 1'b0;
      rateMs          <= 8'h00;
      devMaskStrobe   <= 1'b0;
      devMask         <= 16'h0000;
      powerdownStrobe <= 1'b0;
      resetStrobe     <= 1'b0;
    end else begin
      if (strobes.commit)   kindQ <= strobes.kind;
      if (strobes.snapTime) snapQ <= seconds;
      autopollStrobe  <= strobes.fireAutopoll;
      rateStrobe      <= strobes.fireRate;
      devMaskStrobe   <= strobes.fireMask;
      powerdownStrobe <= strobes.firePower;
      resetStrobe     <= strobes.fireReset;
      if (strobes.fireAutopoll) autopollOn <= (argWord[7:0] != 8'h00);
      if (strobes.fireRate)     rateMs     <= argWord[7:0];
      if (strobes.fireMask)     devMask    <= argWord[15:0];
    end
  end

  assign isOk = (kindQ == RK_OK);

  always_comb begin
    case (txIdx)
      TX_IDX_W'(0): outData = isOk ? TYPE_CTRL : TYPE_ERROR;
      TX_IDX_W'(1): outData = isOk ? 8'h00 :
                              ((kindQ == RK_UNKNOWN) ? ERR_UNKNOWN : ERR_BADARGS);
      TX_IDX_W'(2): outData = isOk ? cmdByte : TYPE_CTRL;
      TX_IDX_W'(3): outData = isOk ? snapQ[31:24] : cmdByte;
      TX_IDX_W'(4): outData = snapQ[23:16];
      TX_IDX_W'(5): outData = snapQ[15:8];
      TX_IDX_W'(6): outData = snapQ[7:0];
      default:      outData = 8'h00;
    endcase
  end

endmodule

// File: rtl/ctl_cmd_dispatch.sv
module ctl_cmd_dispatch
  import ctl_cmd_dispatch_pkg::*;
#(
  parameter int          MAX_ARGS         = 4,
  parameter int          TICKS_PER_SECOND = 250_000_000,
  parameter logic [31:0] RESET_SECONDS    = 32'd2082844800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outData,
  output logic        outLast,
  output logic        autopollStrobe,
  output logic        autopollOn,
  output logic        rateStrobe,
  output logic [7:0]  rateMs,
  output logic        devMaskStrobe,
  output logic [15:0] devMask,
  output logic        powerdownStrobe,
  output logic        resetStrobe
);

  localparam int ARG_CNT_W = $clog2(MAX_ARGS + 2);

  ctrlStrobes_t         strobes;
  logic [TX_IDX_W-1:0]  txIdx;
  logic [7:0]           pktType;
  logic [7:0]           cmdByte;
  logic [ARG_CNT_W-1:0] argCount;
  logic [7:0]           argByte0;

  ctl_cmd_dispatch_ctrl #(.MAX_ARGS(MAX_ARGS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .outReady(outReady),
    .outValid(outValid),
    .outLast (outLast),
    .txIdx   (txIdx),
    .pktType (pktType),
    .cmdByte (cmdByte),
    .argCount(argCount),
    .argByte0(argByte0),
    .strobes (strobes)
  );

  ctl_cmd_dispatch_dpath #(
    .MAX_ARGS        (MAX_ARGS),
    .TICKS_PER_SECOND(TICKS_PER_SECOND),
    .RESET_SECONDS   (RESET_SECONDS)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .inData         (inData),
    .strobes        (strobes),
    .txIdx          (txIdx),
    .pktType        (pktType),
    .cmdByte        (cmdByte),
    .argCount       (argCount),
    .argByte0       (argByte0),
    .outData        (outData),
    .autopollStrobe (autopollStrobe),
    .autopollOn     (autopollOn),
    .rateStrobe     (rateStrobe),
    .rateMs         (rateMs),
    .devMaskStrobe  (devMaskStrobe),
    .devMask        (devMask),
    .powerdownStrobe(powerdownStrobe),
    .resetStrobe    (resetStrobe)
  );

endmodule

// File: rtl/ctl_cmd_dispatch_checker.sv
module ctl_cmd_dispatch_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       autopollStrobe,
  input logic       rateStrobe,
  input logic [7:0] rateMs,
  input logic       devMaskStrobe,
  input logic       powerdownStrobe,
  input logic       resetStrobe
);

  logic firstOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     firstOut <= 1'b1;
    else if (outValid && outReady) firstOut <= outLast;
  end

  a_r13_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  a_r13_no_input_during_reply: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r12_one_strobe_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({autopollStrobe, rateStrobe, devMaskStrobe, powerdownStrobe, resetStrobe}));

  a_r12_powerdown_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    powerdownStrobe |=> !powerdownStrobe);

  a_r12_reset_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resetStrobe |=> !resetStrobe);

  a_r10_rate_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    rateStrobe |-> rateMs != 8'h00);

  a_r3_leading_type_byte: assert property (@(posedge clk) disable iff (!rstN)
    outValid && firstOut |-> (outData == 8'h01 || outData == 8'h02));

endmodule

bind ctl_cmd_dispatch ctl_cmd_dispatch_checker u_checker (.*);

// File: tb/ctl_cmd_dispatch_bench.sv
module ctl_cmd_dispatch_bench;

  localparam int TICKS = 40;
  localparam logic [31:0] EPOCH_1970 = 32'd2082844800;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inReady, inLast, outValid, outReady, outLast;
  logic [7:0] inData, outData, rateMs;
  logic autopollStrobe, autopollOn, rateStrobe, devMaskStrobe, powerdownStrobe, resetStrobe;
  logic [15:0] devMask;

  always #2 clk = ~clk;

  ctl_cmd_dispatch #(.TICKS_PER_SECOND(TICKS)) u_ctl_cmd_dispatch (.*);

  int checks = 0, errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // strobe monitor, sampled at falling edges
  int apCnt = 0, rateCnt = 0, maskCnt = 0, pwrCnt = 0, rstCnt = 0;
  logic apVal; logic [7:0] rateVal; logic [15:0] maskVal;
  always @(negedge clk) if (rstN) begin
    if (autopollStrobe)  begin apCnt++;   apVal   = autopollOn; end
    if (rateStrobe)      begin rateCnt++; rateVal = rateMs;     end
    if (devMaskStrobe)   begin maskCnt++; maskVal = devMask;    end
    if (powerdownStrobe) pwrCnt++;
    if (resetStrobe)     rstCnt++;
  end

  // packet and expectation state
  logic [7:0] pkt [8];
  int pktLen;
  logic [7:0] expB [8];
  int expLen;
  bit expAp, expRate, expMask, expPwr, expRst, isGet, isSet;
  logic expApVal; logic [7:0] expRateVal; logic [15:0] expMaskVal;
  logic [31:0] setVal;
  string tag;
  logic [31:0] baseSec;
  longint baseEdge, acceptEdge;

  task automatic check(input bit ok, input string rtag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rtag, what, act, exp);
    end
  endtask

  function automatic int needArgs(input logic [7:0] c);
    case (c)
      8'h01, 8'h14, 8'h13, 8'h21: return 1;
      8'h19: return 2;
      8'h09: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic mk(input int n, input logic [7:0] b0 = 0, input logic [7:0] b1 = 0,
                    input logic [7:0] b2 = 0, input logic [7:0] b3 = 0,
                    input logic [7:0] b4 = 0, input logic [7:0] b5 = 0,
                    input logic [7:0] b6 = 0);
    pktLen = n;
    pkt[0] = b0; pkt[1] = b1; pkt[2] = b2; pkt[3] = b3;
    pkt[4] = b4; pkt[5] = b5; pkt[6] = b6; pkt[7] = 0;
  endtask

  // expected reply and effects from the requirements
  task automatic computeExpect();
    int n; bit known, good; logic [7:0] c;
    expLen = 0; expAp = 0; expRate = 0; expMask = 0; expPwr = 0; expRst = 0;
    isGet = 0; isSet = 0; tag = "R2";
    if (pktLen >= 2 && pkt[0] == 8'h01) begin
      c = pkt[1]; n = pktLen - 2; known = 1; good = 0;
      case (c)
        8'h01: begin tag = "R9";  good = (n == 1); end
        8'h14: begin tag = "R10"; good = (n == 1) && (pkt[2] != 0); end
        8'h19: begin tag = "R11"; good = (n == 2); end
        8'h0A, 8'h11, 8'h13, 8'h21: begin tag = "R12"; good = (n == needArgs(c)); end
        8'h03: begin tag = "R6";  good = (n == 0); end
        8'h09: begin tag = "R7";  good = (n == 4); end
        default: begin tag = "R4"; known = 0; end
      endcase
      if (!known) begin
        expLen = 4; expB[0] = 2; expB[1] = 8'h02; expB[2] = 1; expB[3] = c;
      end else if (!good) begin
        tag = "R5";
        expLen = 4; expB[0] = 2; expB[1] = 8'h05; expB[2] = 1; expB[3] = c;
      end else begin
        expLen = 3; expB[0] = 1; expB[1] = 0; expB[2] = c;
        case (c)
          8'h01: begin expAp = 1; expApVal = (pkt[2] != 0); end
          8'h14: begin expRate = 1; expRateVal = pkt[2]; end
          8'h19: begin expMask = 1; expMaskVal = {pkt[2], pkt[3]}; end
          8'h0A: expPwr = 1;
          8'h11: expRst = 1;
          8'h03: begin isGet = 1; expLen = 7; end
          8'h09: begin isSet = 1; setVal = {pkt[2], pkt[3], pkt[4], pkt[5]}; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic sendPacket();
    for (int i = 0; i < pktLen; i++) begin
      if ($urandom % 3 == 0) begin inValid = 0; @(negedge clk); end
      inValid = 1; inData = pkt[i]; inLast = (i == pktLen - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 0; inLast = 0;
    acceptEdge = cyc;
  endtask

  task automatic runPacket(input string tagOver);
    int a0, r0, m0, p0, s0, gotN; bit lastSeen, quiet;
    logic [7:0] got [8];
    longint gp, ep; logic [31:0] tval;
    computeExpect();
    if (tagOver != "") tag = tagOver;
    a0 = apCnt; r0 = rateCnt; m0 = maskCnt; p0 = pwrCnt; s0 = rstCnt;
    sendPacket();
    if (isGet) begin
      tval = baseSec + 32'((acceptEdge + 1 - baseEdge - 1) / TICKS);
      expB[3] = tval[31:24]; expB[4] = tval[23:16]; expB[5] = tval[15:8]; expB[6] = tval[7:0];
    end
    if (isSet) begin baseSec = setVal; baseEdge = acceptEdge + 1; end
    // first falling edge after the last-byte accept: still evaluating (R13)
    check(outValid == 0 && inReady == 0, "R13", "evaluation cycle", {outValid, inReady}, 0);
    @(negedge clk);
    if (expLen > 0) begin
      check(outValid == 1, "R13", "reply due one cycle after evaluation", outValid, 1);
      gotN = 0; lastSeen = 0;
      while (!lastSeen && gotN < 8) begin
        outReady = ($urandom % 4 != 0);
        if (outValid && outReady) begin
          got[gotN] = outData; gotN++;
          if (outLast) lastSeen = 1;
        end
        @(negedge clk);
      end
      outReady = 0;
      gp = 0; ep = 0;
      for (int i = 0; i < 7; i++) begin
        gp = (gp << 8) | ((i < gotN) ? longint'(got[i]) : 0);
        ep = (ep << 8) | ((i < expLen) ? longint'(expB[i]) : 0);
      end
      check(gotN == expLen && gp == ep, tag, $sformatf("reply len %0d/%0d", gotN, expLen), gp, ep);
    end else begin
      quiet = 1;
      for (int i = 0; i < 5; i++) begin
        if (outValid) quiet = 0;
        @(negedge clk);
      end
      check(quiet && inReady, tag, "no reply expected", {outValid, inReady}, 1);
    end
    @(negedge clk);
    check(apCnt - a0 == int'(expAp) && rateCnt - r0 == int'(expRate) &&
          maskCnt - m0 == int'(expMask) && pwrCnt - p0 == int'(expPwr) &&
          rstCnt - s0 == int'(expRst), tag, "strobe counts",
          {apCnt - a0, rateCnt - r0, maskCnt - m0, pwrCnt - p0, rstCnt - s0},
          {int'(expAp), int'(expRate), int'(expMask), int'(expPwr), int'(expRst)});
    if (expAp)   check(apVal == expApVal, "R9", "autopoll value", apVal, expApVal);
    if (expRate) check(rateVal == expRateVal, "R10", "rate value", rateVal, expRateVal);
    if (expMask) check(maskVal == expMaskVal, "R11", "mask value", maskVal, expMaskVal);
  endtask

  localparam logic [7:0] CMDS [9] = '{8'h01, 8'h03, 8'h09, 8'h0A, 8'h11, 8'h13, 8'h14, 8'h19, 8'h21};

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; inValid = 0; inData = 0; inLast = 0; outReady = 0;
    repeat (4) @(negedge clk);
    rstN = 1; baseSec = EPOCH_1970; baseEdge = cyc;
    @(negedge clk);
    check(inReady == 1 && outValid == 0 && !autopollStrobe && !rateStrobe && !devMaskStrobe &&
          !powerdownStrobe && !resetStrobe, "R1", "idle after reset",
          {inReady, outValid}, 2'b10);
    mk(2, 1, 8'h03);                         runPacket("R1");
    mk(6, 1, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78); runPacket("R7");
    repeat (100) @(negedge clk);
    mk(2, 1, 8'h03);                         runPacket("R8");
    mk(6, 1, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFF); runPacket("R7");
    repeat (45) @(negedge clk);
    mk(2, 1, 8'h03);                         runPacket("R8");
    mk(2, 1, 8'h7E);                         runPacket("R4");
    mk(3, 1, 8'h03, 8'h00);                  runPacket("R5");
    mk(7, 1, 8'h09, 1, 2, 3, 4, 5);          runPacket("R5");
    mk(3, 1, 8'h14, 8'h00);                  runPacket("R10");
    mk(3, 1, 8'h14, 8'h07);                  runPacket("R10");
    mk(4, 1, 8'h19, 8'hAB, 8'hCD);           runPacket("R11");
    mk(3, 1, 8'h01, 8'h00);                  runPacket("R9");
    mk(3, 1, 8'h01, 8'h05);                  runPacket("R9");
    mk(2, 1, 8'h0A);                         runPacket("R12");
    mk(2, 1, 8'h11);                         runPacket("R12");
    mk(3, 1, 8'h13, 8'h01);                  runPacket("R12");
    mk(3, 1, 8'h21, 8'h00);                  runPacket("R3");
    mk(3, 0, 8'h0A, 8'h00);                  runPacket("R2");
    mk(2, 5, 8'h11);                         runPacket("R2");
    mk(1, 1);                                runPacket("R2");
    for (int k = 0; k < 300; k++) begin
      logic [7:0] t, c; int n, ci;
      t  = ($urandom % 100 < 80) ? 8'h01 : 8'($urandom % 7);
      ci = $urandom % 11;
      c  = (ci < 9) ? CMDS[ci] : 8'(8'h40 + $urandom % 32);
      n  = ($urandom % 100 < 65) ? needArgs(c) : int'($urandom % 6);
      mk(2 + n, t, c, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      if (c == 8'h14 && $urandom % 5 == 0) pkt[2] = 0;
      if ($urandom % 20 == 0) pktLen = 1;
      runPacket("");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule